// File: doc/BRIEF.md
# Bus Clock Divider Search Engine

This unit works out the two clock-divide factors a serial bus controller needs to run its bus at or below a requested rate. Given the frequency of the clock that feeds the controller and the bus frequency wanted, it searches a small range of sample counts. For each sample count it derives the step count that reaches the required overall division. It keeps the pair whose product is the smallest one that still divides enough. It also reports whether even that best pair leaves the bus running too fast.

The engine is sequential and uses one clock. A single-cycle start pulse captures both frequencies. All divisions are done by one shared restoring divider that resolves one quotient bit per clock. When the search is over, a one-cycle done pulse is raised. The results (sample count minus one, step count minus one, an error flag and a flag saying the high-speed step range was used) stay on the outputs until the next search completes. Frequencies may be in any unit, provided the two clamp thresholds are given in the same unit.

Top module: `busdiv_search`

## Requirements
- R1: The target is first clamped to HS_MAX. When the clamped target exceeds FS_MAX, `hs_mode_o` reads 1 and the step limit is STEP_HS. Otherwise `hs_mode_o` reads 0 and the step limit is STEP_FS.
- R2: The required division is ceil(floor(source/2) / clamped target), raised to 1 when it would be 0.
- R3: Sample counts 1 through SMP_MAX are tried in rising order. Each one gets step = ceil(required / sample). A candidate whose step exceeds the limit is skipped. A candidate replaces the stored best only when its product is strictly smaller, so the smallest sample count wins a tie. The search stops at the first kept candidate whose product equals the required division.
- R4: Before the search, the best pair is sample = SMP_MAX and step = limit, with product SMP_MAX × limit. If no candidate is kept, this pair is reported.
- R5: `err_o` is 1 when floor(source / (2 × sample × step)) for the chosen pair is greater than the clamped target. A target of 0 gives `err_o` = 1, `hs_mode_o` = 0 and the default pair for limit STEP_FS.
- R6: `sample_m1_o` and `step_m1_o` carry the chosen sample count and step count, each minus one, as unsigned binary.
- R7: `done_o` is high for exactly one cycle per accepted start. All result outputs change only in that cycle and hold their values afterwards.
- R8: A start pulse that arrives while a search is running is ignored, and the running search completes with its own operands.
- R9: After reset, `done_o`, `err_o`, `hs_mode_o`, `sample_m1_o` and `step_m1_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, captures the operands when idle |
| src_freq_i | input | FREQ_W | Source clock frequency |
| tgt_freq_i | input | FREQ_W | Wanted bus frequency |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Bus would still run faster than the target |
| hs_mode_o | output | 1 | High-speed step limit was applied |
| sample_m1_o | output | $clog2(SMP_MAX) | Chosen sample count minus one |
| step_m1_o | output | $clog2(STEP_FS) | Chosen step count minus one |

## Verification
The bench builds the engine with 16-bit frequencies and the clamp thresholds scaled to 400 and 3400. In that scale the clamp, the switch between the two step limits, and the error case can all be reached with small numbers. The sweep covers sources from 0 to full scale and targets on both sides of each threshold, including 0. It therefore reaches the cases with no qualifying candidate, with an exact early hit, and with the required division pinned to 1. Each result is compared with an arithmetic model of the search. Holding of the outputs after done, and a start issued in the middle of a search, are checked separately.

// File: rtl/busdiv_pkg.sv
package busdiv_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_CAND,
    S_CHK,
    S_FIN
  } srch_state_t;
endpackage

// File: rtl/busdiv_divider.sv
// Restoring shift-subtract divider, one quotient bit per clock.
module busdiv_divider #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  logic [N-1:0] dividend_i,
  input  logic [N-1:0] divisor_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [N-1:0] quot_o,
  output logic [N-1:0] rem_o
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic [N:0]    shifted, diff;

  always_comb begin
    shifted = {rem_q, quo_q[N-1]};
    diff    = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      fin_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        dvs_q  <= divisor_i;
        cnt_q  <= CW'(N - 1);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (!diff[N]) begin
          rem_q <= diff[N-1:0];
          quo_q <= {quo_q[N-2:0], 1'b1};
        end else begin
          rem_q <= shifted[N-1:0];
          quo_q <= {quo_q[N-2:0], 1'b0};
        end
        if (cnt_q == '0) begin
          busy_o <= 1'b0;
          fin_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;
  assign rem_o  = rem_q;

  // R2
  div_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    go_i |-> !busy_o);

  // R3
  div_rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_o && dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/busdiv_keeper.sv
// Holds the best (sample, step) pair seen so far and judges each candidate.
module busdiv_keeper #(
  parameter int FREQ_W  = 32,
  parameter int SMP_MAX = 8,
  parameter int SW      = 4,
  parameter int LW      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic [LW-1:0]     lim_i,
  input  logic              offer_i,
  input  logic [SW-1:0]     smp_i,
  input  logic [FREQ_W-1:0] step_i,
  input  logic [FREQ_W-1:0] req_i,
  output logic              take_o,
  output logic              exact_o,
  output logic [SW-1:0]     best_smp_o,
  output logic [LW-1:0]     best_step_o
);
  localparam int PW = FREQ_W + SW;

  logic [PW-1:0] best_q, mul;
  logic [LW-1:0] lim_q;

  always_comb begin
    mul     = PW'(step_i) * PW'(smp_i);
    take_o  = offer_i && (step_i <= FREQ_W'(lim_q)) && (mul < best_q);
    exact_o = take_o && (mul == PW'(req_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      best_q      <= '0;
      lim_q       <= '0;
      best_smp_o  <= '0;
      best_step_o <= '0;
    end else if (init_i) begin
      lim_q       <= lim_i;
      best_q      <= PW'(SMP_MAX) * PW'(lim_i);
      best_smp_o  <= SW'(SMP_MAX);
      best_step_o <= lim_i;
    end else if (take_o) begin
      best_q      <= mul;
      best_smp_o  <= smp_i;
      best_step_o <= step_i[LW-1:0];
    end
  end

  // R3
  keep_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && !init_i) |=> (best_q < $past(best_q)));

  // R4
  keep_within_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (!init_i && $past(init_i)) |-> (best_step_o <= lim_q));
endmodule

// File: rtl/busdiv_search.sv
module busdiv_search #(
  parameter int FREQ_W  = 32,
  parameter int HS_MAX  = 3400000,
  parameter int FS_MAX  = 400000,
  parameter int SMP_MAX = 8,
  parameter int STEP_FS = 64,
  parameter int STEP_HS = 8,
  localparam int SO_W   = $clog2(SMP_MAX),
  localparam int STO_W  = $clog2(STEP_FS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] src_freq_i,
  input  logic [FREQ_W-1:0] tgt_freq_i,
  output logic              done_o,
  output logic              err_o,
  output logic              hs_mode_o,
  output logic [SO_W-1:0]   sample_m1_o,
  output logic [STO_W-1:0]  step_m1_o
);
  import busdiv_pkg::*;

  localparam int SW = $clog2(SMP_MAX + 1);
  localparam int LW = $clog2(STEP_FS + 1);

  srch_state_t       st;
  logic [FREQ_W-1:0] src_q, tgt_q, req_q;
  logic [SW-1:0]     smp_q;
  logic              kick_q, hs_q, err_q;

  logic [FREQ_W-1:0] tgt_c;
  logic              hs_c;
  logic [LW-1:0]     lim_c;
  logic              accept;

  logic [FREQ_W-1:0] dvd, dvs, quot, rem, ceil_c;
  logic              div_busy, div_fin;

  logic              take, exact;
  logic [SW-1:0]     best_smp;
  logic [LW-1:0]     best_step;
  logic [SW-1:0]     smp_m1;
  logic [LW-1:0]     step_m1;

  always_comb begin
    tgt_c  = (tgt_freq_i > FREQ_W'(HS_MAX)) ? FREQ_W'(HS_MAX) : tgt_freq_i;
    hs_c   = tgt_c > FREQ_W'(FS_MAX);
    lim_c  = hs_c ? LW'(STEP_HS) : LW'(STEP_FS);
    accept = (st == S_IDLE) && start_i;
    ceil_c = quot + FREQ_W'(rem != '0);
    smp_m1  = best_smp - 1'b1;
    step_m1 = best_step - 1'b1;
    unique case (st)
      S_CAND: begin
        dvd = req_q;
        dvs = FREQ_W'(smp_q);
      end
      S_CHK: begin
        dvd = src_q;
        dvs = (FREQ_W'(best_smp) * FREQ_W'(best_step)) << 1;
      end
      default: begin
        dvd = src_q >> 1;
        dvs = tgt_q;
      end
    endcase
  end

  busdiv_divider #(.N(FREQ_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .go_i       (kick_q),
    .dividend_i (dvd),
    .divisor_i  (dvs),
    .busy_o     (div_busy),
    .fin_o      (div_fin),
    .quot_o     (quot),
    .rem_o      (rem)
  );

  busdiv_keeper #(.FREQ_W(FREQ_W), .SMP_MAX(SMP_MAX), .SW(SW), .LW(LW)) u_keep (
    .clk         (clk),
    .rst         (rst),
    .init_i      (accept),
    .lim_i       (lim_c),
    .offer_i     ((st == S_CAND) && div_fin),
    .smp_i       (smp_q),
    .step_i      (ceil_c),
    .req_i       (req_q),
    .take_o      (take),
    .exact_o     (exact),
    .best_smp_o  (best_smp),
    .best_step_o (best_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      src_q       <= '0;
      tgt_q       <= '0;
      req_q       <= '0;
      smp_q       <= '0;
      kick_q      <= 1'b0;
      hs_q        <= 1'b0;
      err_q       <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      hs_mode_o   <= 1'b0;
      sample_m1_o <= '0;
      step_m1_o   <= '0;
    end else begin
      done_o <= 1'b0;
      kick_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          src_q <= src_freq_i;
          tgt_q <= tgt_c;
          hs_q  <= hs_c;
          if (tgt_c == '0) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            err_q  <= 1'b0;
            kick_q <= 1'b1;
            st     <= S_REQ;
          end
        end
        S_REQ: if (div_fin) begin
          req_q  <= (ceil_c == '0) ? FREQ_W'(1) : ceil_c;
          smp_q  <= SW'(1);
          kick_q <= 1'b1;
          st     <= S_CAND;
        end
        S_CAND: if (div_fin) begin
          kick_q <= 1'b1;
          if (exact || smp_q == SW'(SMP_MAX)) st <= S_CHK;
          else smp_q <= smp_q + 1'b1;
        end
        S_CHK: if (div_fin) begin
          err_q <= quot > tgt_q;
          st    <= S_FIN;
        end
        default: begin
          done_o      <= 1'b1;
          err_o       <= err_q;
          hs_mode_o   <= hs_q;
          sample_m1_o <= smp_m1[SO_W-1:0];
          step_m1_o   <= step_m1[STO_W-1:0];
          st          <= S_IDLE;
        end
      endcase
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(sample_m1_o) && $stable(step_m1_o) && $stable(err_o)));

  // R1
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (32'(step_m1_o) <= (hs_mode_o ? 32'(STEP_HS - 1) : 32'(STEP_FS - 1))));

  // R8
  busy_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE) |=> $stable(src_q));

  // R3
  cand_index_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_CAND) |-> (smp_q >= SW'(1) && smp_q <= SW'(SMP_MAX)));

  // R2
  kick_idle_div_chk: assert property (@(posedge clk) disable iff (rst)
    kick_q |-> !div_busy);
endmodule

// File: tb/busdiv_search_tb.sv
module busdiv_search_tb_top;
  localparam int FW = 16;
  localparam int HS = 3400;
  localparam int FS = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [FW-1:0] src_freq_i = '0;
  logic [FW-1:0] tgt_freq_i = '0;
  logic done_o, err_o, hs_mode_o;
  logic [2:0] sample_m1_o;
  logic [5:0] step_m1_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  busdiv_search #(.FREQ_W(FW), .HS_MAX(HS), .FS_MAX(FS)) dut_i (
    .clk (clk), .rst (rst), .start_i (start_i),
    .src_freq_i (src_freq_i), .tgt_freq_i (tgt_freq_i),
    .done_o (done_o), .err_o (err_o), .hs_mode_o (hs_mode_o),
    .sample_m1_o (sample_m1_o), .step_m1_o (step_m1_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Arithmetic model of the search (R1-R6).
  task automatic model(input int src, input int tgt,
                       output int es, output int est, output int eerr, output int ehs);
    int t, lim, bs, bst, best, req;
    t    = (tgt > HS) ? HS : tgt;
    ehs  = (t > FS) ? 1 : 0;
    lim  = ehs ? 8 : 64;
    bs   = 8;
    bst  = lim;
    best = 8 * lim;
    if (t == 0) begin
      eerr = 1;
    end else begin
      req = ((src / 2) + t - 1) / t;
      if (req == 0) req = 1;
      for (int s = 1; s <= 8; s++) begin
        int stp, m;
        stp = (req + s - 1) / s;
        m   = stp * s;
        if (stp <= lim && m < best) begin
          best = m; bs = s; bst = stp;
          if (m == req) break;
        end
      end
      eerr = ((src / (2 * bs * bst)) > t) ? 1 : 0;
    end
    es  = bs - 1;
    est = bst - 1;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (done_o) begin ok = 1; break; end
    end
  endtask

  task automatic run(input int src, input int tgt, input bit mid_start);
    int es, est, eerr, ehs;
    bit ok;
    logic [2:0] hs_s;
    logic [5:0] hst;
    model(src, tgt, es, est, eerr, ehs);
    @(negedge clk);
    src_freq_i = FW'(src);
    tgt_freq_i = FW'(tgt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (mid_start) begin
      repeat (4) @(negedge clk);
      src_freq_i = FW'(src ^ 16'h5a5a);
      tgt_freq_i = FW'(tgt + 977);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done(ok);
    chk("R7 done seen", int'(ok), 1);
    if (!ok) return;
    chk(mid_start ? "R8 sample" : "R3 R6 sample", int'(sample_m1_o), es);
    chk(mid_start ? "R8 step" : "R3 R4 R6 step", int'(step_m1_o), est);
    chk("R5 err", int'(err_o), eerr);
    chk("R1 hs", int'(hs_mode_o), ehs);
    hs_s = sample_m1_o;
    hst  = step_m1_o;
    repeat (3) @(negedge clk);
    chk("R7 done one cycle", int'(done_o), 0);
    chk("R7 hold", int'({hs_s, hst} == {sample_m1_o, step_m1_o}), 1);
  endtask

  initial begin
    automatic int srcs[13] = '{0, 1, 2, 3, 50, 799, 800, 1000, 4095, 13000, 26000, 48000, 65535};
    automatic int specials[12] = '{0, 1, 2, 3, 399, 400, 401, 3399, 3400, 3401, 4000, 65535};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 done", int'(done_o), 0);
    chk("R9 err", int'(err_o), 0);
    chk("R9 hs", int'(hs_mode_o), 0);
    chk("R9 sample", int'(sample_m1_o), 0);
    chk("R9 step", int'(step_m1_o), 0);
    foreach (srcs[i]) begin
      foreach (specials[j]) run(srcs[i], specials[j], 1'b0);
      for (int k = 1; k <= 22; k++) run(srcs[i], (k * k * 11 + k * 7) % 3600 + 1, 1'b0);
    end
    // R8 start during a running search
    run(48000, 1000, 1'b1);
    run(13000, 500, 1'b1);
    run(65535, 3000, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 195000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule